// File: doc/BRIEF.md
# Sanitized Four-Lane Float Multiplier

This block multiplies two four-component single-precision vectors lane by lane, as one stage of a shader vector unit. All four lanes (x, y, z, w) work in parallel and share one valid strobe. Special values follow the shader convention rather than IEEE 754. A zero operand forces the lane product to +0.0 whenever the other operand is not NaN, including when that other operand is infinity. Denormal operands count as zero, and results too small for the normal range are flushed to signed zero.

Results land in a destination register bank held inside the block. A per-lane write mask decides which components take the new product; the others keep their old contents. A homogeneous-mode input replaces the w component of the first operand with 1.0 before the multiply, which lets a following adder tree form homogeneous dot products. The product appears in the destination register one clock after the input strobe, together with `out_valid`.

Top module: `smul_vec4`

## Requirements
- R1: All four lanes are computed in parallel. The destination register and `out_valid` update on the first rising clock edge after `in_valid` is sampled high. `out_valid` is high for exactly the cycles that follow an accepted input.
- R2: For two normal operands, the product sign is the XOR of the operand signs. The 48-bit significand product is rounded to 24 bits, round to nearest with ties to even.
- R3: If either operand is NaN (exponent field 255, nonzero fraction), the lane result is 0x7FC00000. This rule takes priority over every other special case.
- R4: An operand with exponent field 0 (zero or denormal) makes the lane result 0x00000000 when the other operand is not NaN. This also holds when the other operand is infinity, and in every case the result is positive.
- R5: Infinity times a nonzero non-NaN operand gives infinity with sign equal to the XOR of the operand signs.
- R6: If the biased exponent after rounding is 255 or more, the result is signed infinity (0x7F800000 with the product sign in bit 31).
- R7: If the biased exponent after rounding is 0 or less, the result is signed zero (the product sign in bit 31, all other bits 0).
- R8: Lane i occupies bits [32i+31:32i] of `src_a`, `src_b` and `dest` (lane 0 = x, lane 3 = w). When `dest_mask[i]` is 1, lane i of `dest` takes the new product. When it is 0, lane i keeps its value.
- R9: When `homog` is 1, lane 3 of the first operand is replaced with 0x3F800000 (1.0) before multiplication. Lanes 0 to 2 are unaffected.
- R10: Reset clears `dest` to all zeros and `out_valid` to 0. While `in_valid` is low, `dest` does not change, whatever the operands and mask are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operands and mask are valid this cycle |
| homog | input | 1 | Force lane 3 of the first operand to 1.0 |
| dest_mask | input | 4 | Per-lane destination write enable |
| src_a | input | 128 | First operand vector, four fp32 lanes |
| src_b | input | 128 | Second operand vector, four fp32 lanes |
| out_valid | output | 1 | Destination register was updated by the previous input |
| dest | output | 128 | Destination register, four fp32 lanes |

## Verification
The bench sweeps every ordered pair from a list of fourteen special and boundary encodings: signed zeros, denormals, both infinities, quiet and signalling NaNs, extremes of the normal range and ordinary values. This separates the zero-times-infinity rule from plain NaN propagation and from signed-infinity results. Several thousand operand pairs with fully random bit patterns then exercise rounding ties, overflow and flush-to-zero across the whole exponent range. These are checked against an integer reference that rounds by remainder comparison. Rotating write masks, idle cycles with changing operands, and homogeneous mode with varied w operands show that held lanes stay put and that only lane 3 of the first operand is replaced.

// File: rtl/smul_pkg.sv
package smul_pkg;

    localparam int FP_W      = 32;
    localparam int EXP_W     = 8;
    localparam int MAN_W     = 23;
    localparam int SIG_W     = MAN_W + 1;
    localparam int PROD_W    = 2 * SIG_W;
    localparam int EXP_BIAS  = (1 << (EXP_W - 1)) - 1;
    localparam int EXP_ALL1  = (1 << EXP_W) - 1;

    localparam logic [FP_W-1:0] CANON_NAN = 32'h7FC0_0000;
    localparam logic [FP_W-1:0] FP_ONE    = 32'h3F80_0000;

    typedef enum logic [1:0] {
        CLS_ZERO,
        CLS_NORM,
        CLS_INF,
        CLS_NAN
    } fclass_e;

    typedef struct packed {
        logic             sign;
        logic [EXP_W-1:0] exp;
        logic [MAN_W-1:0] man;
    } fp_t;

    // signed exponent with headroom for sum, overflow and underflow
    typedef logic signed [EXP_W+1:0] sexp_t;

    function automatic fclass_e classify(input fp_t f);
        if (f.exp == '0)
            return CLS_ZERO;
        else if (f.exp == EXP_W'(EXP_ALL1))
            return (f.man != '0) ? CLS_NAN : CLS_INF;
        else
            return CLS_NORM;
    endfunction

    function automatic fp_t signed_inf(input logic s);
        fp_t r;
        r.sign = s;
        r.exp  = '1;
        r.man  = '0;
        return r;
    endfunction

    function automatic fp_t signed_zero(input logic s);
        fp_t r;
        r.sign = s;
        r.exp  = '0;
        r.man  = '0;
        return r;
    endfunction

endpackage

// File: rtl/smul_operand_prep.sv
module smul_operand_prep
    import smul_pkg::*;
#(
    parameter int LANES = 4
) (
    input  fp_t [LANES-1:0] a_in,
    input  logic            homog,
    output fp_t [LANES-1:0] a_out
);
    localparam int W_LANE = LANES - 1;

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        if (i == W_LANE) begin : g_w
            assign a_out[i] = homog ? fp_t'(FP_ONE) : a_in[i];
        end else begin : g_pass
            assign a_out[i] = a_in[i];
        end
    end

endmodule

// File: rtl/fmul_lane.sv
module fmul_lane
    import smul_pkg::*;
(
    input  fp_t a,
    input  fp_t b,
    output fp_t p
);
    fclass_e            cls_a, cls_b;
    logic [PROD_W-1:0]  sig_prod;
    logic               top_bit;
    logic [SIG_W-1:0]   norm_sig;
    logic               guard_b, sticky_b, rnd_up;
    logic [SIG_W:0]     rounded;
    logic               rnd_carry;
    sexp_t              exp_sum, exp_res;
    logic               p_sign;

    always_comb begin
        cls_a    = classify(a);
        cls_b    = classify(b);
        p_sign   = a.sign ^ b.sign;

        sig_prod = {1'b1, a.man} * {1'b1, b.man};
        top_bit  = sig_prod[PROD_W-1];

        if (top_bit) begin
            norm_sig = sig_prod[PROD_W-1 -: SIG_W];
            guard_b  = sig_prod[PROD_W-1-SIG_W];
            sticky_b = |sig_prod[PROD_W-2-SIG_W:0];
        end else begin
            norm_sig = sig_prod[PROD_W-2 -: SIG_W];
            guard_b  = sig_prod[PROD_W-2-SIG_W];
            sticky_b = |sig_prod[PROD_W-3-SIG_W:0];
        end

        rnd_up    = guard_b & (sticky_b | norm_sig[0]);
        rounded   = {1'b0, norm_sig} + (SIG_W+1)'(rnd_up);
        rnd_carry = rounded[SIG_W];

        exp_sum = sexp_t'({2'b00, a.exp}) + sexp_t'({2'b00, b.exp}) - sexp_t'(EXP_BIAS);
        exp_res = exp_sum + sexp_t'({1'b0, top_bit}) + sexp_t'({1'b0, rnd_carry});

        if (cls_a == CLS_NAN || cls_b == CLS_NAN) begin
            p = fp_t'(CANON_NAN);
        end else if (cls_a == CLS_ZERO || cls_b == CLS_ZERO) begin
            // shader rule: zero wins over infinity and is always positive
            p = signed_zero(1'b0);
        end else if (cls_a == CLS_INF || cls_b == CLS_INF) begin
            p = signed_inf(p_sign);
        end else if (exp_res >= sexp_t'(EXP_ALL1)) begin
            p = signed_inf(p_sign);
        end else if (exp_res <= sexp_t'(0)) begin
            p = signed_zero(p_sign);
        end else begin
            p.sign = p_sign;
            p.exp  = exp_res[EXP_W-1:0];
            p.man  = rnd_carry ? '0 : rounded[MAN_W-1:0];
        end
    end

endmodule

// File: rtl/smul_dest_bank.sv
module smul_dest_bank
    import smul_pkg::*;
#(
    parameter int LANES = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    input  logic [LANES-1:0] lane_en,
    input  fp_t  [LANES-1:0] prod,
    output fp_t  [LANES-1:0] dest_q,
    output logic             valid_q
);

    always_ff @(posedge clk) begin
        if (rst)
            valid_q <= 1'b0;
        else
            valid_q <= in_valid;
    end

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        always_ff @(posedge clk) begin
            if (rst)
                dest_q[i] <= '0;
            else if (in_valid && lane_en[i])
                dest_q[i] <= prod[i];
        end
    end

endmodule

// File: rtl/smul_vec4.sv
module smul_vec4
    import smul_pkg::*;
#(
    parameter int LANES = 4
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  in_valid,
    input  logic                  homog,
    input  logic [LANES-1:0]      dest_mask,
    input  logic [LANES*FP_W-1:0] src_a,
    input  logic [LANES*FP_W-1:0] src_b,
    output logic                  out_valid,
    output logic [LANES*FP_W-1:0] dest
);
    fp_t [LANES-1:0] a_raw, a_eff, b_vec, prod_vec, dest_vec;

    assign a_raw = src_a;
    assign b_vec = src_b;

    smul_operand_prep #(.LANES(LANES)) prep_i (
        .a_in  (a_raw),
        .homog (homog),
        .a_out (a_eff)
    );

    for (genvar i = 0; i < LANES; i++) begin : g_mul
        fmul_lane mul_i (
            .a (a_eff[i]),
            .b (b_vec[i]),
            .p (prod_vec[i])
        );
    end

    smul_dest_bank #(.LANES(LANES)) bank_i (
        .clk      (clk),
        .rst      (rst),
        .in_valid (in_valid),
        .lane_en  (dest_mask),
        .prod     (prod_vec),
        .dest_q   (dest_vec),
        .valid_q  (out_valid)
    );

    assign dest = dest_vec;

endmodule

// File: rtl/smul_vec4_chk.sv
module smul_vec4_chk
    import smul_pkg::*;
#(
    parameter int LANES = 4
) (
    input logic                  clk,
    input logic                  rst,
    input logic                  in_valid,
    input logic                  homog,
    input logic [LANES-1:0]      dest_mask,
    input logic [LANES*FP_W-1:0] src_a,
    input logic [LANES*FP_W-1:0] src_b,
    input logic                  out_valid,
    input logic [LANES*FP_W-1:0] dest
);
    // R1
    valid_follows_chk: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);

    // R1
    valid_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);

    // R10
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> $stable(dest));

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        fp_t a_l, b_l;
        assign a_l = (i == LANES-1 && homog) ? fp_t'(FP_ONE) : fp_t'(src_a[i*FP_W +: FP_W]);
        assign b_l = fp_t'(src_b[i*FP_W +: FP_W]);

        // R8
        masked_hold_chk: assert property (@(posedge clk) disable iff (rst)
            (in_valid && !dest_mask[i]) |=> $stable(dest[i*FP_W +: FP_W]));

        // R3
        nan_out_chk: assert property (@(posedge clk) disable iff (rst)
            (in_valid && dest_mask[i] && (classify(a_l) == CLS_NAN || classify(b_l) == CLS_NAN))
            |=> dest[i*FP_W +: FP_W] == CANON_NAN);

        // R4
        zero_wins_chk: assert property (@(posedge clk) disable iff (rst)
            (in_valid && dest_mask[i] && classify(a_l) != CLS_NAN && classify(b_l) != CLS_NAN
             && (classify(a_l) == CLS_ZERO || classify(b_l) == CLS_ZERO))
            |=> dest[i*FP_W +: FP_W] == '0);
    end

    // R9
    homog_w_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && homog && dest_mask[LANES-1] && src_b[(LANES-1)*FP_W +: FP_W] == FP_ONE)
        |=> dest[(LANES-1)*FP_W +: FP_W] == FP_ONE);

endmodule

bind smul_vec4 smul_vec4_chk #(.LANES(LANES)) chk_i (.*);

// File: tb/smul_vec4_tb_top.sv
module smul_vec4_tb_top;
    localparam int LANES = 4;
    localparam int W = 32;

    logic               clk = 1'b0;
    logic               rst = 1'b1;
    logic               in_valid = 1'b0;
    logic               homog = 1'b0;
    logic [LANES-1:0]   dest_mask = '0;
    logic [LANES*W-1:0] src_a = '0;
    logic [LANES*W-1:0] src_b = '0;
    logic               out_valid;
    logic [LANES*W-1:0] dest;

    logic [LANES*W-1:0] model;
    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #10 clk = ~clk;

    smul_vec4 #(.LANES(LANES)) dut_i (
        .clk(clk), .rst(rst), .in_valid(in_valid), .homog(homog),
        .dest_mask(dest_mask), .src_a(src_a), .src_b(src_b),
        .out_valid(out_valid), .dest(dest)
    );

    logic [31:0] specials [14] = '{
        32'h0000_0000, 32'h8000_0000, 32'h0000_0001, 32'h807F_FFFF,
        32'h7F80_0000, 32'hFF80_0000, 32'h7FC0_0000, 32'hFF80_0001,
        32'h3F80_0000, 32'hBFC0_0000, 32'h7F7F_FFFF, 32'h0080_0000,
        32'h4040_0000, 32'h1F80_0001
    };

    function automatic bit is_nan(input logic [31:0] f);
        return f[30:23] == 8'hFF && f[22:0] != 0;
    endfunction

    // reference product, rounding done by remainder comparison
    function automatic logic [31:0] ref_mul(input logic [31:0] a, input logic [31:0] b,
                                            output string tag);
        logic s;
        int ea, eb, k, sh, e;
        longint unsigned pm, q, r, half;
        s = a[31] ^ b[31];
        ea = int'(a[30:23]);
        eb = int'(b[30:23]);
        if (is_nan(a) || is_nan(b)) begin tag = "R3"; return 32'h7FC0_0000; end
        if (ea == 0 || eb == 0) begin tag = "R4"; return 32'h0; end
        if (ea == 255 || eb == 255) begin tag = "R5"; return {s, 8'hFF, 23'h0}; end
        pm = longint'({1'b1, a[22:0]}) * longint'({1'b1, b[22:0]});
        k = pm[47] ? 47 : 46;
        sh = k - 23;
        q = pm >> sh;
        r = pm - (q << sh);
        half = 64'd1 << (sh - 1);
        if (r > half || (r == half && q[0])) q = q + 1;
        if (q == (64'd1 << 24)) begin q = q >> 1; k = k + 1; end
        e = ea + eb - 127 + (k - 46);
        if (e >= 255) begin tag = "R6"; return {s, 8'hFF, 23'h0}; end
        if (e <= 0) begin tag = "R7"; return {s, 31'h0}; end
        tag = "R2";
        return {s, e[7:0], q[22:0]};
    endfunction

    task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %08h expected %08h", tag, act, exp);
        end
    endtask

    // called at a negedge; returns at the next negedge after checking
    task automatic run_op(input logic [LANES*W-1:0] a, input logic [LANES*W-1:0] b,
                          input logic [LANES-1:0] m, input logic h);
        string tags [LANES];
        logic [31:0] ea;
        src_a = a; src_b = b; dest_mask = m; homog = h; in_valid = 1'b1;
        for (int i = 0; i < LANES; i++) begin
            ea = (i == LANES-1 && h) ? 32'h3F80_0000 : a[i*W +: W];
            if (m[i]) model[i*W +: W] = ref_mul(ea, b[i*W +: W], tags[i]);
            else tags[i] = "R8";
        end
        @(negedge clk);
        in_valid = 1'b0;
        chk({31'h0, out_valid}, 32'h1, "R1");
        for (int i = 0; i < LANES; i++)
            chk(dest[i*W +: W], model[i*W +: W], tags[i]);
    endtask

    initial begin
        model = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R10 reset state
        chk(dest[31:0] | dest[63:32] | dest[95:64] | dest[127:96], 32'h0, "R10");
        chk({31'h0, out_valid}, 32'h0, "R10");

        // R3 R4 R5 sweep of all special pairs, rotating lane
        for (int i = 0; i < 14; i++)
            for (int j = 0; j < 14; j++) begin
                logic [LANES*W-1:0] a, b;
                for (int l = 0; l < LANES; l++) begin
                    a[l*W +: W] = 32'h4000_0000 + 32'(l);
                    b[l*W +: W] = 32'h3FC0_0000;
                end
                a[((i + j) % LANES)*W +: W] = specials[i];
                b[((i + j) % LANES)*W +: W] = specials[j];
                run_op(a, b, 4'hF, 1'b0);
            end

        // R2 R6 R7 random operands across all exponents, rotating masks (R8)
        for (int n = 0; n < 3000; n++) begin
            logic [LANES*W-1:0] a, b;
            for (int l = 0; l < LANES; l++) begin
                a[l*W +: W] = $urandom;
                b[l*W +: W] = $urandom;
                if (n % 3 == 0) begin
                    a[l*W+23 +: 8] = 8'd64 + 8'($urandom_range(0, 127));
                    b[l*W+23 +: 8] = 8'd64 + 8'($urandom_range(0, 127));
                end
            end
            run_op(a, b, 4'(n % 16), 1'b0);
        end

        // R9 homogeneous mode: lane 3 of operand a ignored, others used
        for (int n = 0; n < 200; n++) begin
            logic [LANES*W-1:0] a, b;
            for (int l = 0; l < LANES; l++) begin
                a[l*W +: W] = $urandom;
                b[l*W +: W] = $urandom;
            end
            if (n % 4 == 0) a[3*W +: W] = 32'h7FC0_0000;
            if (n % 4 == 1) a[3*W +: W] = 32'h0000_0000;
            run_op(a, b, 4'hF, 1'b1);
        end
        // R9 w operand 2.0 under homog gives b unchanged
        run_op({32'h4000_0000, 96'h0}, {32'h4080_0000, 96'h0}, 4'h8, 1'b1);
        chk(dest[127:96], 32'h4080_0000, "R9");

        // R10 idle cycles with changing inputs leave dest alone
        for (int n = 0; n < 20; n++) begin
            src_a = {4{$urandom}};
            src_b = {4{$urandom}};
            dest_mask = 4'hF;
            in_valid = 1'b0;
            @(negedge clk);
            chk({31'h0, out_valid}, 32'h0, "R1");
            for (int l = 0; l < LANES; l++)
                chk(dest[l*W +: W], model[l*W +: W], "R10");
        end

        // R8 mask zero with valid leaves every lane
        run_op({4{32'h4000_0000}}, {4{32'h4000_0000}}, 4'h0, 1'b0);

        done = 1;
    end

    initial begin
        int cyc = 0;
        while (!done && cyc < 150000) begin
            @(posedge clk);
            cyc++;
        end
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual timeout expected completion");
        end
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule